// File: doc/BRIEF.md
# ADC Result Byte Registers with Read Lock

This block sits between an analog-to-digital conversion engine and a byte-wide processor bus. Each time the engine finishes a conversion it pulses a done strobe with a 10-bit result. The block keeps that result and shows it as two bytes, a low byte and a high byte. A justify input selects one of two layouts. Right justified packs the value at the bottom of the 16-bit pair. Left justified packs it at the top, so a reader that needs only 8 bits of precision can read the high byte alone.

To keep the two bytes from ever mixing two conversions, software reads the low byte first. That read freezes the stored result. A later high-byte read unfreezes it. A conversion that finishes while the result is frozen is thrown away, but it still sets the completion flag. The flag stays set until software writes one to clear it. The flag drives the interrupt output when interrupts are enabled.

Top module: `adc_result_lock`

## Requirements
- R1: With `left_just_i` low, `lo_byte_o` equals stored result bits 7:0. `hi_byte_o` holds result bits 9:8 in its bits 1:0, and bits 7:2 are zero.
- R2: With `left_just_i` high, `hi_byte_o` equals stored result bits 9:2. `lo_byte_o` holds result bits 1:0 in its bits 7:6, and bits 5:0 are zero.
- R3: A change of `left_just_i` re-lays out the stored result on the byte outputs in the same cycle, with no new conversion.
- R4: When `done_i` is high in a cycle where the registers are unlocked and `rd_lo_i` is low, `res_i` is stored. The new bytes appear from the following cycle.
- R5: A cycle with `rd_lo_i` high locks the registers from the next cycle on. A `done_i` in the same cycle as that low-byte read is also discarded.
- R6: A cycle with `rd_hi_i` high releases the lock from the next cycle on. A high-byte read without a preceding low-byte read returns the stored value and leaves updates enabled.
- R7: A `done_i` while the registers are locked changes neither byte output.
- R8: `flag_o` is set the cycle after every `done_i`, including a discarded one, and stays set until cleared.
- R9: A cycle with `flag_clr_i` high clears `flag_o` from the next cycle, unless `done_i` is high in the same cycle, in which case the set wins.
- R10: `irq_o` is high exactly when `flag_o` and `irq_en_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_i | input | 10 | Conversion result from the engine |
| done_i | input | 1 | One-cycle conversion complete strobe |
| left_just_i | input | 1 | 1 = left justified layout, 0 = right justified |
| rd_lo_i | input | 1 | Low-byte read strobe from the bus |
| rd_hi_i | input | 1 | High-byte read strobe from the bus |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the completion flag |
| irq_en_i | input | 1 | Interrupt enable |
| lo_byte_o | output | 8 | Low data byte |
| hi_byte_o | output | 8 | High data byte |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A lock bit stuck set shows up as byte outputs that stay frozen after a high-byte read. The next conversion strobe exposes it one cycle later. A lock bit that never sets lets a completion during a low/high read pair change the bytes in the cycle after the strobe. A wrong layout shows up at once on the byte outputs, in the same cycle as the justify change. A flag that misses a discarded completion is visible on `flag_o` and `irq_o` one cycle after that strobe.

// File: rtl/adc_lock_pkg.sv
package adc_lock_pkg;
    parameter int ADC_RES_W = 10;
    parameter int BYTE_W    = 8;
    localparam int HI_BITS  = ADC_RES_W - BYTE_W;

    typedef struct packed {
        logic [ADC_RES_W-1:0] res;
        logic                 lock;
    } store_t;

    typedef struct packed {
        logic flag;
    } flag_t;
endpackage

// File: rtl/adc_lock_store.sv
module adc_lock_store
    import adc_lock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADC_RES_W-1:0] res_i,
    input  logic                 done_i,
    input  logic                 rd_lo_i,
    input  logic                 rd_hi_i,
    output logic [ADC_RES_W-1:0] res_o,
    output logic                 locked_o
);
    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a low-byte read in this very cycle already pins the old value
        if (done_i && !st_q.lock && !rd_lo_i) begin
            st_d.res = res_i;
        end
        if (rd_hi_i) begin
            st_d.lock = 1'b0;
        end else if (rd_lo_i) begin
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o    = st_q.res;
    assign locked_o = st_q.lock;
endmodule

// File: rtl/adc_lock_fmt.sv
module adc_lock_fmt
    import adc_lock_pkg::*;
(
    input  logic [ADC_RES_W-1:0] res_i,
    input  logic                 left_i,
    output logic [BYTE_W-1:0]    lo_o,
    output logic [BYTE_W-1:0]    hi_o
);
    localparam int PAD_W = 2 * BYTE_W - ADC_RES_W;

    always_comb begin
        if (left_i) begin
            hi_o = res_i[ADC_RES_W-1 -: BYTE_W];
            lo_o = {res_i[HI_BITS-1:0], {PAD_W{1'b0}}};
        end else begin
            lo_o = res_i[BYTE_W-1:0];
            hi_o = {{PAD_W{1'b0}}, res_i[ADC_RES_W-1:BYTE_W]};
        end
    end
endmodule

// File: rtl/adc_lock_flag.sv
module adc_lock_flag
    import adc_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (done_i) begin
            fl_d.flag = 1'b1;
        end else if (clr_i) begin
            fl_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flag_o = fl_q.flag;
    assign irq_o  = fl_q.flag & en_i;
endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock
    import adc_lock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADC_RES_W-1:0] res_i,
    input  logic                 done_i,
    input  logic                 left_just_i,
    input  logic                 rd_lo_i,
    input  logic                 rd_hi_i,
    input  logic                 flag_clr_i,
    input  logic                 irq_en_i,
    output logic [BYTE_W-1:0]    lo_byte_o,
    output logic [BYTE_W-1:0]    hi_byte_o,
    output logic                 flag_o,
    output logic                 irq_o
);
    logic [ADC_RES_W-1:0] kept_res;
    logic                 locked;

    adc_lock_store store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_i    (res_i),
        .done_i   (done_i),
        .rd_lo_i  (rd_lo_i),
        .rd_hi_i  (rd_hi_i),
        .res_o    (kept_res),
        .locked_o (locked)
    );

    adc_lock_fmt fmt_i (
        .res_i  (kept_res),
        .left_i (left_just_i),
        .lo_o   (lo_byte_o),
        .hi_o   (hi_byte_o)
    );

    adc_lock_flag flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (done_i),
        .clr_i  (flag_clr_i),
        .en_i   (irq_en_i),
        .flag_o (flag_o),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/adc_result_lock_chk.sv
module adc_result_lock_chk
    import adc_lock_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADC_RES_W-1:0] res_i,
    input logic                 done_i,
    input logic                 left_just_i,
    input logic                 rd_lo_i,
    input logic                 rd_hi_i,
    input logic                 flag_clr_i,
    input logic [BYTE_W-1:0]    lo_byte_o,
    input logic [BYTE_W-1:0]    hi_byte_o,
    input logic                 flag_o,
    input logic [ADC_RES_W-1:0] kept_res,
    input logic                 locked
);
    // R1
    right_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !left_just_i |-> hi_byte_o[BYTE_W-1:HI_BITS] == '0);
    // R2
    left_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_just_i |-> lo_byte_o[BYTE_W-HI_BITS-1:0] == '0);
    // R4
    take_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !locked && !rd_lo_i) |=> kept_res == $past(res_i));
    // R5
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo_i && !rd_hi_i) |=> locked);
    // R6
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i |=> !locked);
    // R7
    hold_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(kept_res));
    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> flag_o);
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !done_i) |=> !flag_o);
endmodule

bind adc_result_lock adc_result_lock_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_i       (res_i),
    .done_i      (done_i),
    .left_just_i (left_just_i),
    .rd_lo_i     (rd_lo_i),
    .rd_hi_i     (rd_hi_i),
    .flag_clr_i  (flag_clr_i),
    .lo_byte_o   (lo_byte_o),
    .hi_byte_o   (hi_byte_o),
    .flag_o      (flag_o),
    .kept_res    (kept_res),
    .locked      (locked)
);

// File: tb/adc_result_lock_tb_top.sv
`timescale 1ns/1ps
module adc_result_lock_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] res_i = '0;
    logic       done_i = 1'b0;
    logic       left_just_i = 1'b0;
    logic       rd_lo_i = 1'b0;
    logic       rd_hi_i = 1'b0;
    logic       flag_clr_i = 1'b0;
    logic       irq_en_i = 1'b0;
    logic [7:0] lo_byte_o, hi_byte_o;
    logic       flag_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_result_lock dut_i (
        .clk(clk), .rst_n(rst_n), .res_i(res_i), .done_i(done_i),
        .left_just_i(left_just_i), .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
        .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i),
        .lo_byte_o(lo_byte_o), .hi_byte_o(hi_byte_o),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock with the given strobes; returns at the following negedge
    task automatic step(input bit done, input logic [9:0] val, input bit lo,
                        input bit hi, input bit clr);
        done_i = done; res_i = val; rd_lo_i = lo; rd_hi_i = hi; flag_clr_i = clr;
        @(negedge clk);
        done_i = 0; rd_lo_i = 0; rd_hi_i = 0; flag_clr_i = 0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 reset lo", lo_byte_o, 0);
        check("R1 reset hi", hi_byte_o, 0);
        check("R8 reset flag", flag_o, 0);
        check("R10 reset irq", irq_o, 0);
    endtask

    task automatic t_right();
        left_just_i = 0;
        step(1, 10'h2A5, 0, 0, 0);
        check("R4 R1 right lo", lo_byte_o, 8'hA5);
        check("R4 R1 right hi", hi_byte_o, 8'h02);
        check("R8 flag after done", flag_o, 1);
    endtask

    task automatic t_left();
        left_just_i = 1; #1;
        check("R2 R3 left hi", hi_byte_o, 8'hA9);
        check("R2 R3 left lo", lo_byte_o, 8'h40);
        left_just_i = 0; #1;
        check("R3 back right lo", lo_byte_o, 8'hA5);
    endtask

    task automatic t_lock();
        step(0, 0, 0, 0, 1);
        check("R9 flag cleared", flag_o, 0);
        step(0, 0, 1, 0, 0);
        step(1, 10'h1FF, 0, 0, 0);
        check("R7 locked lo", lo_byte_o, 8'hA5);
        check("R7 locked hi", hi_byte_o, 8'h02);
        check("R8 flag on dropped", flag_o, 1);
        step(0, 0, 0, 1, 0);
        step(1, 10'h1FF, 0, 0, 0);
        check("R6 released lo", lo_byte_o, 8'hFF);
        check("R6 released hi", hi_byte_o, 8'h01);
    endtask

    task automatic t_same_cycle();
        step(1, 10'h0C3, 1, 0, 0);
        check("R5 same-cycle drop lo", lo_byte_o, 8'hFF);
        step(1, 10'h0C3, 0, 0, 0);
        check("R5 lock holds lo", lo_byte_o, 8'hFF);
        step(0, 0, 0, 1, 0);
    endtask

    task automatic t_hi_only();
        step(0, 0, 0, 1, 0);
        check("R6 hi-only read value", hi_byte_o, 8'h01);
        step(1, 10'h300, 0, 0, 0);
        check("R6 after hi-only lo", lo_byte_o, 8'h00);
        check("R6 after hi-only hi", hi_byte_o, 8'h03);
    endtask

    task automatic t_irq();
        step(0, 0, 0, 0, 1);
        irq_en_i = 1; #1;
        check("R10 irq idle", irq_o, 0);
        step(1, 10'h155, 0, 0, 0);
        check("R10 irq raised", irq_o, 1);
        irq_en_i = 0; #1;
        check("R10 irq masked", irq_o, 0);
        irq_en_i = 1;
        step(1, 10'h155, 0, 0, 1);
        check("R9 set wins over clear", flag_o, 1);
        step(0, 0, 0, 0, 1);
        check("R9 clear", flag_o, 0);
        check("R10 irq after clear", irq_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1;
        @(negedge clk); #1;
        t_right();
        t_left();
        t_lock();
        t_same_cycle();
        t_hi_only();
        t_irq();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule